// File: doc/BRIEF.md
# Serial Audio Transmitter with Mute and Stop

This block turns parallel audio samples into a serial stream that a two-channel audio receiver can read. Samples are written into a small byte-organised FIFO through a plain write port. Each new data word is loaded when the channel-select line changes level. It is shifted out most significant bit first, one bit per bit-clock tick. The block is clocked by a system clock. `bclk_tick` is a one-cycle strobe that marks each falling edge of the transmit bit clock, and all serial activity happens on the system clock edges where that strobe is high.

The channel-select line comes from one of two places. In master mode an internal counter toggles it every `half_period + 1` ticks. In slave mode it follows the `ws_in` pin. Samples can be 8, 16 or 32 bits wide. In stereo operation every word takes a fresh sample. In mono operation one sample is sent in both halves of a frame. Two separate quiet controls exist. Mute silences the line while the FIFO keeps draining. Stop silences the line and also freezes the FIFO. An empty FIFO at a word start sends silence and sets a sticky underrun flag.

Top module: `audio_ser_tx`

## Requirements
- R1: `width_sel` selects the sample width: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. The sample occupies the low bits of `wr_data`. It is sent MSB first, and every tick of a channel phase beyond the sample width drives 0.
- R2: The effective channel select is the value in force at a tick (`ws_out`). At the first tick where it differs from its value at the previous tick, a word starts. After that tick `sd_out` carries the word's MSB, and each following tick carries the next bit.
- R3: In stereo mode (`mono`=0) every word start removes one sample from the FIFO, in write order. Words sent with `ws_out`=0 are left and words sent with `ws_out`=1 are right.
- R4: In mono mode (`mono`=1) a word start with `ws_out`=0 removes a sample. A word start with `ws_out`=1 resends the sample taken at the most recent low-phase start, and sends 0 if no such sample exists since reset.
- R5: In master mode (`master_mode`=1) `ws_out` starts at 0 after reset and inverts every `half_period + 1` ticks. It never changes in a cycle without a tick.
- R6: In slave mode (`master_mode`=0) `ws_out` equals `ws_in`.
- R7: While `mute`=1, samples are still removed from the FIFO exactly as without mute, but `sd_out` is 0 after every tick.
- R8: While `stop`=1, no sample is removed from the FIFO, the underrun flag is not set, and `sd_out` is 0 after every tick.
- R9: The FIFO holds 8 bytes. A write of one sample (1, 2 or 4 bytes by R1) is accepted only when `wr_ready`=1, which means that many bytes are free. `fifo_level` counts the stored bytes, and a write with `wr_ready`=0 is dropped.
- R10: A word start that needs a sample while the FIFO holds fewer bytes than one sample sends 0 and sets `underrun`. The flag stays set until `underrun_clr` is pulsed in a cycle with no new underrun.
- R11: After reset `sd_out`=0, `ws_out`=0 in master mode, `fifo_level`=0 and `underrun`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_tick | input | 1 | One-cycle strobe per falling edge of the bit clock |
| master_mode | input | 1 | 1: channel select from the internal counter, 0: from `ws_in` |
| ws_in | input | 1 | External channel select used in slave mode |
| half_period | input | CNT_W (9) | Channel phase length minus one, in ticks (master mode) |
| width_sel | input | 2 | Sample width code (R1) |
| mono | input | 1 | 1: each sample is sent in both channel phases |
| mute | input | 1 | Silence the line while the FIFO keeps draining |
| stop | input | 1 | Silence the line and freeze the FIFO |
| wr_en | input | 1 | Write one sample into the FIFO |
| wr_data | input | 32 | Sample to write, right-aligned |
| underrun_clr | input | 1 | Clear the underrun flag |
| wr_ready | output | 1 | FIFO has room for one sample of the current width |
| fifo_level | output | clog2(FIFO_BYTES+1) (4) | Bytes stored in the FIFO |
| ws_out | output | 1 | Effective channel select |
| sd_out | output | 1 | Serial data |
| underrun | output | 1 | Sticky FIFO-empty flag |

## Verification
The bench acts as an independent receiver and decodes the serial line at each change of `ws_out`. It is swept over every width in both stereo and mono. The channel phase is deliberately longer than the widest sample, so a serializer that failed to shift in zeros would show nonzero tail bits. An off-by-one start tick would give every decoded word a shifted value. Mono sweeps start on a right phase, so a design that popped on the wrong phase, or did not resend the held sample, would fall out of step with the expected FIFO order. Each fill ends with a write that cannot fit, and each drain runs past the end of the data: a FIFO that accepted too much or lost a byte fails the level checks, and a missing underrun flag shows at the end of the run. Mute and stop runs check the line and the remaining level separately, so mixing up the two controls is caught. The master run measures every phase length of `ws_out`.

// File: rtl/ast_pkg.sv
package ast_pkg;

  localparam int SAMPLE_W = 32;

  typedef enum logic [1:0] {
    WID_8   = 2'd0,
    WID_16  = 2'd1,
    WID_32  = 2'd2,
    WID_32X = 2'd3
  } wid_e;

  // bytes moved through the FIFO per sample
  function automatic logic [2:0] wid_bytes(input wid_e sel);
    case (sel)
      WID_8:   return 3'd1;
      WID_16:  return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // right-aligned sample moved to the top of a SAMPLE_W word, upper junk dropped
  function automatic logic [SAMPLE_W-1:0] msb_align(input logic [SAMPLE_W-1:0] s,
                                                      input wid_e sel);
    case (sel)
      WID_8:   return {s[7:0], 24'h0};
      WID_16:  return {s[15:0], 16'h0};
      default: return s;
    endcase
  endfunction

endpackage

// File: rtl/ast_byte_fifo.sv
module ast_byte_fifo #(
  parameter int FIFO_BYTES = 8,
  localparam int PTR_W = $clog2(FIFO_BYTES),
  localparam int LVL_W = $clog2(FIFO_BYTES + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [2:0]                   nbytes,
  input  logic [ast_pkg::SAMPLE_W-1:0] push_data,
  input  logic                         pop,
  output logic [ast_pkg::SAMPLE_W-1:0] pop_data,
  output logic [LVL_W-1:0]             level,
  output logic                         room_ok,
  output logic                         avail_ok
);
  localparam int LANES = ast_pkg::SAMPLE_W / 8;

  logic [7:0]       mem [FIFO_BYTES];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  assign room_ok  = (int'(level) + int'(nbytes)) <= FIFO_BYTES;
  assign avail_ok = int'(level) >= int'(nbytes);
  assign do_push  = push && room_ok;
  assign do_pop   = pop && avail_ok;

  always_comb begin
    pop_data = '0;
    for (int i = 0; i < LANES; i++) begin
      if (3'(i) < nbytes) pop_data[8*i +: 8] = mem[PTR_W'(rd_ptr + PTR_W'(i))];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (do_push && (3'(i) < nbytes)) mem[PTR_W'(wr_ptr + PTR_W'(i))] <= push_data[8*i +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + PTR_W'(nbytes);
      if (do_pop)  rd_ptr <= rd_ptr + PTR_W'(nbytes);
      level <= level + (do_push ? LVL_W'(nbytes) : '0) - (do_pop ? LVL_W'(nbytes) : '0);
    end
  end
endmodule

// File: rtl/ast_ws_gen.sv
module ast_ws_gen #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             enable,
  input  logic [CNT_W-1:0] half_period,
  output logic             ws
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ws  <= 1'b0;
    end else if (tick && enable) begin
      if (cnt >= half_period) begin
        cnt <= '0;
        ws  <= ~ws;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ast_serializer.sv
module ast_serializer (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  input  logic                         ws_now,
  input  ast_pkg::wid_e                width,
  input  logic                         mono,
  input  logic                         mute,
  input  logic                         stop,
  input  logic                         avail,
  input  logic [ast_pkg::SAMPLE_W-1:0] rd_data,
  output logic                         pop,
  output logic                         word_start,
  output logic                         uflow,
  output logic                         sd
);
  localparam int SW = ast_pkg::SAMPLE_W;

  logic          ws_q;
  logic [SW-1:0] sh, held, fresh, word;
  logic          want_pop, quiet, next_bit;

  assign word_start = tick && (ws_now != ws_q);
  assign want_pop   = word_start && !stop && !(mono && ws_now);
  assign pop        = want_pop && avail;
  assign uflow      = want_pop && !avail;
  assign quiet      = mute || stop;

  always_comb begin
    fresh = pop ? ast_pkg::msb_align(rd_data, width) : '0;
    if (stop)              word = '0;
    else if (mono && ws_now) word = held;
    else                   word = fresh;
    next_bit = word_start ? word[SW-1] : sh[SW-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_q <= 1'b0;
      sh   <= '0;
      held <= '0;
      sd   <= 1'b0;
    end else if (tick) begin
      ws_q <= ws_now;
      sh   <= word_start ? (word << 1) : (sh << 1);
      sd   <= quiet ? 1'b0 : next_bit;
      if (want_pop && mono) held <= fresh;
    end
  end
endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx #(
  parameter int FIFO_BYTES = 8,
  parameter int CNT_W = 9
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bclk_tick,
  input  logic                            master_mode,
  input  logic                            ws_in,
  input  logic [CNT_W-1:0]                half_period,
  input  logic [1:0]                      width_sel,
  input  logic                            mono,
  input  logic                            mute,
  input  logic                            stop,
  input  logic                            wr_en,
  input  logic [31:0]                     wr_data,
  input  logic                            underrun_clr,
  output logic                            wr_ready,
  output logic [$clog2(FIFO_BYTES+1)-1:0] fifo_level,
  output logic                            ws_out,
  output logic                            sd_out,
  output logic                            underrun
);
  ast_pkg::wid_e width;
  logic          ws_gen, pop_evt, word_start, uflow_evt, avail;
  logic [31:0]   rd_data;

  assign width  = ast_pkg::wid_e'(width_sel);
  assign ws_out = master_mode ? ws_gen : ws_in;

  ast_ws_gen #(.CNT_W(CNT_W)) u_ws (
    .clk(clk), .rst_n(rst_n), .tick(bclk_tick), .enable(master_mode),
    .half_period(half_period), .ws(ws_gen)
  );

  ast_byte_fifo #(.FIFO_BYTES(FIFO_BYTES)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(wr_en), .nbytes(ast_pkg::wid_bytes(width)),
    .push_data(wr_data), .pop(pop_evt), .pop_data(rd_data), .level(fifo_level),
    .room_ok(wr_ready), .avail_ok(avail)
  );

  ast_serializer u_ser (
    .clk(clk), .rst_n(rst_n), .tick(bclk_tick), .ws_now(ws_out), .width(width),
    .mono(mono), .mute(mute), .stop(stop), .avail(avail), .rd_data(rd_data),
    .pop(pop_evt), .word_start(word_start), .uflow(uflow_evt), .sd(sd_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            underrun <= 1'b0;
    else if (uflow_evt)    underrun <= 1'b1;
    else if (underrun_clr) underrun <= 1'b0;
  end
endmodule

// File: rtl/audio_ser_tx_chk.sv
module audio_ser_tx_chk #(
  parameter int FIFO_BYTES = 8,
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bclk_tick,
  input logic             master_mode,
  input logic             mute,
  input logic             stop,
  input logic             wr_en,
  input logic             wr_ready,
  input logic             underrun_clr,
  input logic [LVL_W-1:0] fifo_level,
  input logic             ws_out,
  input logic             sd_out,
  input logic             underrun,
  input logic             pop_evt,
  input logic             word_start
);
  p_stop_blocks_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> !pop_evt);

  p_quiet_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_tick && (mute || stop)) |=> !sd_out);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_level) <= FIFO_BYTES);

  p_reject_keeps_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ready && !pop_evt) |=> (fifo_level == $past(fifo_level)));

  p_underrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !underrun_clr) |=> underrun);

  p_pop_on_word_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt |-> word_start);

  p_ws_moves_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && $past(master_mode) && !$past(bclk_tick)) |-> $stable(ws_out));
endmodule

bind audio_ser_tx audio_ser_tx_chk #(
  .FIFO_BYTES(FIFO_BYTES), .LVL_W($clog2(FIFO_BYTES+1))
) chk_i (
  .clk(clk), .rst_n(rst_n), .bclk_tick(bclk_tick), .master_mode(master_mode),
  .mute(mute), .stop(stop), .wr_en(wr_en), .wr_ready(wr_ready),
  .underrun_clr(underrun_clr), .fifo_level(fifo_level), .ws_out(ws_out),
  .sd_out(sd_out), .underrun(underrun), .pop_evt(pop_evt), .word_start(word_start)
);

// File: tb/audio_ser_tx_tb_top.sv
module audio_ser_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FIFO_B = 8;
  localparam int SLV_P = 34;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk_tick = 1'b0, master_mode = 1'b0, ws_in = 1'b0;
  logic [8:0]  half_period = 9'd20;
  logic [1:0]  width_sel = 2'd0;
  logic        mono = 1'b0, mute = 1'b0, stop = 1'b0;
  logic        wr_en = 1'b0, underrun_clr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wr_ready, ws_out, sd_out, underrun;
  logic [3:0]  fifo_level;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_ser_tx dut_i (
    .clk(clk), .rst_n(rst_n), .bclk_tick(bclk_tick), .master_mode(master_mode),
    .ws_in(ws_in), .half_period(half_period), .width_sel(width_sel), .mono(mono),
    .mute(mute), .stop(stop), .wr_en(wr_en), .wr_data(wr_data),
    .underrun_clr(underrun_clr), .wr_ready(wr_ready), .fifo_level(fifo_level),
    .ws_out(ws_out), .sd_out(sd_out), .underrun(underrun)
  );

  // bench model state
  logic [31:0] q[$];
  int          m_lvl, m_bpw, m_bits;
  logic        m_ur;
  logic [31:0] m_held;
  // receiver state
  logic        rx_prev, rx_active, rx_tail_bad;
  int          rx_idx, tick_no, last_change, n_changes;
  logic [31:0] rx_acc, rx_exp;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bclk_tick = 1'b0; wr_en = 1'b0; underrun_clr = 1'b0; ws_in = 1'b0;
    q.delete();
    m_lvl = 0; m_ur = 1'b0; m_held = '0;
    rx_prev = 1'b0; rx_active = 1'b0; rx_idx = 0; rx_acc = '0; rx_tail_bad = 1'b0;
    tick_no = 0; last_change = 0; n_changes = 0;
    m_bpw  = (width_sel == 2'd0) ? 1 : (width_sel == 2'd1) ? 2 : 4;
    m_bits = 8 * m_bpw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [31:0] pat(input int k);
    logic [31:0] v;
    v = 32'hA5C3_0F96 ^ (32'(k) * 32'h1357_9BDF);
    return (m_bits == 32) ? v : (v & ((32'd1 << m_bits) - 1));
  endfunction

  task automatic push_sample(input logic [31:0] d);
    bit fits;
    fits = (m_lvl + m_bpw) <= FIFO_B;
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d | (m_bits == 32 ? 32'h0 : 32'hFFFF_FFFF << m_bits); // junk above width
    #1 chk(wr_ready == fits, "R9 wr_ready", 32'(wr_ready), 32'(fits));
    @(negedge clk);
    wr_en = 1'b0;
    if (fits) begin
      q.push_back(d);
      m_lvl += m_bpw;
    end
    chk(fifo_level == 4'(m_lvl), "R9 fifo_level after write", 32'(fifo_level), 32'(m_lvl));
  endtask

  task automatic finish_word();
    if (rx_active)
      chk((rx_acc == rx_exp) && !rx_tail_bad, "R1 R2 R3 R4 word value / zero tail",
          rx_acc, rx_exp);
  endtask

  task automatic one_tick();
    logic ws_seen;
    logic [31:0] e;
    @(negedge clk);
    if (!master_mode && tick_no > 0 && (tick_no % SLV_P) == 0) ws_in = ~ws_in;
    bclk_tick = 1'b1;
    #1 ws_seen = ws_out;
    @(negedge clk);
    bclk_tick = 1'b0;
    tick_no++;
    if (ws_seen != rx_prev) begin
      finish_word();
      n_changes++;
      if (master_mode)
        chk((tick_no - 1 - last_change) == int'(half_period) + 1, "R5 phase length",
            32'(tick_no - 1 - last_change), 32'(half_period) + 1);
      else if (n_changes == 1)
        chk(ws_out == ws_in, "R6 ws follows input", 32'(ws_out), 32'(ws_in));
      last_change = tick_no - 1;
      if (stop) e = '0;
      else if (mono && ws_seen) e = m_held;
      else begin
        if (q.size() > 0) begin
          e = q.pop_front();
          m_lvl -= m_bpw;
        end else begin
          e = '0;
          m_ur = 1'b1;
        end
        if (mono) m_held = e;
      end
      if (mute) e = '0;
      rx_exp = e; rx_active = 1'b1; rx_idx = 0; rx_acc = '0; rx_tail_bad = 1'b0;
    end
    rx_prev = ws_seen;
    if (rx_active) begin
      if (rx_idx < m_bits) rx_acc = {rx_acc[30:0], sd_out};
      else if (sd_out) rx_tail_bad = 1'b1;
      rx_idx++;
    end
  endtask

  task automatic fill_full();
    int n;
    n = FIFO_B / m_bpw;
    for (int k = 0; k < n; k++) push_sample(pat(k + 7 * int'(width_sel)));
    push_sample(32'h5A5A_5A5A & ((m_bits == 32) ? 32'hFFFF_FFFF : ((32'd1 << m_bits) - 1)));
  endtask

  task automatic run_ticks(input int n);
    for (int t = 0; t < n; t++) one_tick();
  endtask

  task automatic end_checks(input string tag);
    chk(fifo_level == 4'(m_lvl), {tag, " level after run"}, 32'(fifo_level), 32'(m_lvl));
    chk(underrun == m_ur, {"R10 underrun flag ", tag}, 32'(underrun), 32'(m_ur));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    // R11 reset state, master mode
    master_mode = 1'b1; half_period = 9'd20; width_sel = 2'd1;
    do_reset();
    chk(sd_out == 1'b0, "R11 sd_out after reset", 32'(sd_out), 0);
    chk(ws_out == 1'b0, "R11 ws_out after reset", 32'(ws_out), 0);
    chk(fifo_level == 0, "R11 fifo_level after reset", 32'(fifo_level), 0);
    chk(underrun == 1'b0, "R11 underrun after reset", 32'(underrun), 0);

    // R5 master timing with stereo 16-bit data
    fill_full();
    run_ticks(21 * 9);
    end_checks("R5 master");

    // sweep: every width, stereo and mono, slave mode (R1 R2 R3 R4 R6 R9 R10)
    master_mode = 1'b0;
    for (int w = 0; w < 3; w++) begin
      for (int mo = 0; mo < 2; mo++) begin
        width_sel = 2'(w); mono = mo[0];
        do_reset();
        fill_full();
        run_ticks(SLV_P * (((mo != 0) ? 2 : 1) * (FIFO_B / m_bpw) + 5));
        end_checks("R3 R4 sweep");
        @(negedge clk); underrun_clr = 1'b1;
        @(negedge clk); underrun_clr = 1'b0;
        chk(underrun == 1'b0, "R10 clear", 32'(underrun), 0);
      end
    end

    // R7 mute: FIFO drains, line silent
    width_sel = 2'd0; mono = 1'b0; mute = 1'b1;
    do_reset();
    fill_full();
    run_ticks(SLV_P * 6);
    end_checks("R7 mute");
    mute = 1'b0;

    // R8 stop: FIFO frozen, line silent, no underrun
    width_sel = 2'd2; mono = 1'b1; stop = 1'b1;
    do_reset();
    fill_full();
    run_ticks(SLV_P * 6);
    end_checks("R8 stop");
    chk(fifo_level == 4'(FIFO_B), "R8 nothing popped", 32'(fifo_level), FIFO_B);
    stop = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule